// File: doc/BRIEF.md
# Slave Arbiter with Idle Parking

This block sits on the slave side of a multi-master bus matrix and decides which master owns that slave. Each master raises a request line for as long as it wants the slave; the block answers with a registered one-hot grant and the index of the connected master. A master keeps the slave until it lowers its request, which marks the end of its burst. When that happens and others are waiting, the next owner is chosen round-robin, starting with the master after the one most recently served.

When nobody is asking, the slave is parked according to a per-slave policy input: disconnected, left on the master that was served last, or placed on a fixed master given by a 4-bit index. A parked master whose request arrives already holds the grant, so it loses no cycle. Every other master sees its grant one clock after it raises its request. Each slave in the matrix has its own copy of this block with its own policy inputs, so different slaves can park on different masters.

Top module: `slave_park_arbiter`

## Requirements
- R1: Synchronous active-high reset clears the grant, drops the connected flag and sets the last-served master index to 0, so that a last-served park right after reset lands on master 0.
- R2: At most one grant bit is high; when the connected flag is high, the grant bit at the connected index is the one that is set, and when it is low no grant bit is set.
- R3: While the owning master keeps its request high, the grant does not move, whatever other masters request.
- R4: A master that does not hold the grant and raises its request while the slave is free gets its grant in the first clock edge after the request is seen (one cycle of latency).
- R5: When the owner lowers its request and several masters are requesting, the grant goes to the first requester found by searching upward (wrapping at the master count) from the master after the one last served.
- R6: Policy code 2'b00 (none) and the reserved code 2'b11 both leave the slave unconnected, with every grant bit low, in a cycle that follows one with no request.
- R7: Policy code 2'b01 (last served) parks the slave on the last master whose request was high while it held the grant; if that master then requests, its grant is already present and stays, with no lost cycle.
- R8: Policy code 2'b10 (fixed) parks the slave on the master named by the 4-bit fixed index; under the other codes the fixed index has no effect on the grant.
- R9: Under the fixed policy, a fixed index not below the master count leaves the slave unconnected.
- R10: Changes to the policy code or fixed index never move the grant away from an owner whose request is still high; they act only once the slave goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_MASTERS | Request lines, one per master, held high for a whole burst |
| park_mode_i | input | 2 | Idle policy: 00 none, 01 last served, 10 fixed, 11 treated as none |
| park_fixed_i | input | 4 | Master index used by the fixed policy |
| grant_o | output | NUM_MASTERS | Registered one-hot grant |
| conn_valid_o | output | 1 | High when the slave is connected to some master |
| conn_idx_o | output | IDX_W | Index of the connected master, meaningful when conn_valid_o is high |

## Verification
The hardest situation to reach is the zero-latency case of the last-served policy: the parked master must first be served, with its request high during at least one edge while it owns the grant, then release so the slave goes idle, and only then request again, while a second master's request must arrive while the first one is merely parked. The stimulus builds these serve, release and re-request sequences explicitly, and also changes the policy inputs in the middle of a held burst, before a long random phase with sparse and sticky requests that a behavioural model follows on every clock.

// File: rtl/arb_park_pkg.sv
package arb_park_pkg;

    localparam int FIX_W = 4;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'b00,
        PARK_LAST  = 2'b01,
        PARK_FIXED = 2'b10,
        PARK_RSVD  = 2'b11
    } park_mode_e;

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] after_idx,
    output logic             found,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = int'(after_idx) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found   = 1'b1;
                win_idx = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/arb_park_sel.sv
module arb_park_sel
    import arb_park_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [1:0]       mode,
    input  logic [FIX_W-1:0] fixed_idx,
    input  logic [IDX_W-1:0] last_idx,
    output logic             park_valid,
    output logic [IDX_W-1:0] park_idx
);
    park_mode_e m;

    always_comb begin
        m          = park_mode_e'(mode);
        park_valid = 1'b0;
        park_idx   = '0;
        case (m)
            PARK_LAST: begin
                park_valid = 1'b1;
                park_idx   = last_idx;
            end
            PARK_FIXED: begin
                park_valid = (int'(fixed_idx) < N);
                park_idx   = IDX_W'(fixed_idx);
            end
            default: begin
                park_valid = 1'b0;
                park_idx   = '0;
            end
        endcase
    end
endmodule

// File: rtl/slave_park_arbiter.sv
module slave_park_arbiter
    import arb_park_pkg::*;
#(
    parameter int NUM_MASTERS = 8,
    localparam int IDX_W = idx_width(NUM_MASTERS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [1:0]             park_mode_i,
    input  logic [FIX_W-1:0]       park_fixed_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic                   conn_valid_o,
    output logic [IDX_W-1:0]       conn_idx_o
);
    logic             own_v_q;
    logic [IDX_W-1:0] own_q;
    logic [IDX_W-1:0] last_q;
    logic             busy;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             park_valid;
    logic [IDX_W-1:0] park_idx;

    assign busy = own_v_q && req_i[own_q];

    arb_rr_pick #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_pick (
        .req       (req_i),
        .after_idx (last_q),
        .found     (pick_found),
        .win_idx   (pick_idx)
    );

    arb_park_sel #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_park (
        .mode       (park_mode_i),
        .fixed_idx  (park_fixed_i),
        .last_idx   (last_q),
        .park_valid (park_valid),
        .park_idx   (park_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            own_v_q <= 1'b0;
            own_q   <= '0;
            last_q  <= '0;
        end else if (busy) begin
            last_q  <= own_q;
        end else if (pick_found) begin
            own_v_q <= 1'b1;
            own_q   <= pick_idx;
        end else begin
            own_v_q <= park_valid;
            own_q   <= park_idx;
        end
    end

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_grant
        assign grant_o[g] = own_v_q && (own_q == IDX_W'(g));
    end

    assign conn_valid_o = own_v_q;
    assign conn_idx_o   = own_q;

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (conn_valid_o && req_i[conn_idx_o]) |=> (conn_valid_o && $stable(conn_idx_o)));

    p_none_r6: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0 && (park_mode_i == 2'b00 || park_mode_i == 2'b11)) |=> (grant_o == '0));

    p_last_r7: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0 && park_mode_i == 2'b01) |=> (conn_valid_o && conn_idx_o == $past(last_q)));

    p_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0 && park_mode_i == 2'b10 && int'(park_fixed_i) < NUM_MASTERS)
        |=> (conn_valid_o && conn_idx_o == $past(park_fixed_i[IDX_W-1:0])));

    p_fixed_range_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0 && park_mode_i == 2'b10 && int'(park_fixed_i) >= NUM_MASTERS) |=> !conn_valid_o);

    p_request_served_r4: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0 && !(conn_valid_o && req_i[conn_idx_o])) |=> conn_valid_o);
endmodule

// File: tb/sim_slave_park_arbiter.sv
module sim_slave_park_arbiter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [1:0]   mode = 2'b00;
    logic [3:0]   fixv = 4'd0;
    logic [N-1:0] grant;
    logic         cval;
    logic [2:0]   cidx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int m_v = 0;
    int m_own = 0;
    int m_last = 0;

    always #10 clk = ~clk;

    slave_park_arbiter #(.NUM_MASTERS(N)) u0 (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .park_mode_i  (mode),
        .park_fixed_i (fixv),
        .grant_o      (grant),
        .conn_valid_o (cval),
        .conn_idx_o   (cidx)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [N-1:0] exp_grant(input int v, input int i);
        return v ? (N'(1) << i) : '0;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_v = 0; m_own = 0; m_last = 0;
        end else if (m_v && req[m_own]) begin
            m_last = m_own;
        end else if (req != '0) begin
            int pos;
            pos = m_last;
            for (int k = 0; k < N; k++) begin
                pos = (pos + 1) % N;
                if (req[pos]) break;
            end
            m_v = 1; m_own = pos;
        end else if (mode == 2'b01) begin
            m_v = 1; m_own = m_last;
        end else if (mode == 2'b10 && fixv < N) begin
            m_v = 1; m_own = fixv;
        end else begin
            m_v = 0;
        end
    endtask

    task automatic cmp_model();
        checks++;
        if (grant !== exp_grant(m_v, m_own) || cval !== (m_v != 0) ||
            (m_v != 0 && cidx !== 3'(m_own))) begin
            errors++;
            $display("FAIL R2 model cycle %0d: actual grant %b valid %0b idx %0d expected grant %b valid %0d idx %0d",
                     cyc, grant, cval, cidx, exp_grant(m_v, m_own), m_v, m_own);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [1:0] md, input logic [3:0] f);
        req = r; mode = md; fixv = f;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp_model();
    endtask

    task automatic expect_conn(input string tag, input int ev, input int ei);
        checks++;
        if (grant !== exp_grant(ev, ei) || cval !== (ev != 0)) begin
            errors++;
            $display("FAIL %s: actual grant %b valid %0b expected grant %b valid %0d",
                     tag, grant, cval, exp_grant(ev, ei), ev);
        end
    endtask

    initial begin
        @(negedge clk);
        step('0, 2'b01, 4'd5);
        step('0, 2'b01, 4'd5);
        rst = 1'b0;
        expect_conn("R1 reset grant clear", 0, 0);
        step('0, 2'b01, 4'd5);
        expect_conn("R1 last index cleared to 0", 1, 0);

        step('0, 2'b00, 4'd0);
        expect_conn("R6 none policy idle", 0, 0);
        step(8'b0000_1000, 2'b00, 4'd0);
        expect_conn("R4 one cycle latency m3", 1, 3);
        step(8'b0010_1000, 2'b00, 4'd0);
        expect_conn("R3 owner keeps grant", 1, 3);
        step(8'b0010_1010, 2'b00, 4'd0);
        expect_conn("R3 owner keeps grant again", 1, 3);
        step(8'b0010_0010, 2'b00, 4'd0);
        expect_conn("R5 round robin after m3 picks m5", 1, 5);
        step(8'b0000_0010, 2'b00, 4'd0);
        expect_conn("R5 next requester m1", 1, 1);
        step('0, 2'b11, 4'd2);
        expect_conn("R6 reserved code idle", 0, 0);

        step(8'b0100_0000, 2'b01, 4'd2);
        expect_conn("R4 grant m6", 1, 6);
        step(8'b0100_0000, 2'b01, 4'd2);
        step('0, 2'b01, 4'd2);
        expect_conn("R7 parked on last m6", 1, 6);
        step('0, 2'b01, 4'd2);
        expect_conn("R8 fixed index ignored under last", 1, 6);
        step(8'b0100_0000, 2'b01, 4'd2);
        expect_conn("R7 zero latency for parked m6", 1, 6);
        step('0, 2'b01, 4'd2);
        step(8'b0000_0100, 2'b01, 4'd2);
        expect_conn("R4 non parked m2 one cycle", 1, 2);

        step('0, 2'b10, 4'd4);
        expect_conn("R8 fixed park m4", 1, 4);
        step('0, 2'b10, 4'd9);
        expect_conn("R9 fixed index out of range", 0, 0);
        step('0, 2'b10, 4'd4);
        step(8'b0000_0010, 2'b10, 4'd4);
        expect_conn("R4 m1 while parked on m4", 1, 1);
        step(8'b0000_0010, 2'b00, 4'd7);
        expect_conn("R10 config change mid burst", 1, 1);
        step(8'b0000_0010, 2'b10, 4'd7);
        expect_conn("R10 config change mid burst fixed", 1, 1);
        step('0, 2'b00, 4'd7);
        expect_conn("R10 config applies when idle", 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] r;
            logic [1:0] md;
            logic [3:0] f;
            md = mode; f = fixv; r = req;
            if ($urandom % 40 == 0) md = 2'($urandom);
            if ($urandom % 40 == 0) f = 4'($urandom % 10);
            case ($urandom % 4)
                0: r = '0;
                1: r = N'($urandom);
                default: ;
            endcase
            if ($urandom % 8 == 0) r = r & ~(N'(1) << cidx);
            step(r, md, f);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule